// File: doc/BRIEF.md
# Polyphase Horizontal Resampling Filter

This block resamples one video line horizontally with a polyphase FIR filter. It keeps a sliding window of the most recent input pixels. For every output sample it forms a weighted sum of that window, using a coefficient set picked by a 6-bit phase. The block moves one pixel per clock. An external phase generator supplies one control word per step. The word carries the phase and three flags: whether a new input pixel enters the window, whether an output pixel is produced, and whether the line ends after this step.

Coefficients sit in an on-block bank with 64 phases. Software loads it through a simple write port. Each 32-bit word holds two neighbouring signed 16-bit taps. The taps are fixed point with 12 fractional bits, so a row that sums to 4096 has unity gain. The sum is rounded to the nearest integer, clamped to the unsigned pixel range and registered on a valid/ready output. At both ends of a line the window is padded by repeating the edge pixel, so no stale data enters the sum.

Top module: `hscale_poly`

## Requirements
- R1: After reset, outValid is low, and a control word that asks for neither a shift nor an emit is accepted (ctlReady high).
- R2: Coefficient word address p*(NTAPS/2)+j holds the taps 2j and 2j+1 of phase p. Tap 2j sits in bits 15:0 and tap 2j+1 in bits 31:16, each as a signed 16-bit value.
- R3: A write to a word address at or above 64*(NTAPS/2) changes no stored coefficient.
- R4: An emitted pixel is computed as follows. Take the sum over k of tap k times window slot k, with slot 0 the oldest pixel and slot NTAPS-1 the newest. The window used is the one after this step's shift. Add 2048 to the sum, then shift it right arithmetically by 12.
- R5: A result below 0 is output as 0, and a result above 255 is output as 255.
- R6: The first shift of a line (after reset, or after a step marked end-of-line) fills every window slot with the pixel it takes in.
- R7: Once a pixel marked last has been taken in, later shifts feed the newest window pixel back in, take no input, and hold inReady low. This lasts until an end-of-line step.
- R8: A control word is accepted (ctlReady) exactly when two conditions hold. First, a pixel is available if the word needs one (a shift before the last pixel). Second, the output register is free (outValid low or outReady high) if the word emits. inReady is high exactly when an accepted word would take in a pixel.
- R9: An emitted pixel appears on outData with outValid high in the cycle after the step. It stays unchanged while outReady is low.
- R10: A coefficient write in the same cycle as an emit that reads that word does not affect that emit. The new value applies from the next cycle.
- R11: A step marked end-of-line makes the next shift start a new line. The window is filled again and input is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Coefficient word write strobe |
| cfgAddr | input | 8 | Coefficient word address |
| cfgData | input | 32 | Two packed signed taps |
| ctlValid | input | 1 | Control word present |
| ctlReady | output | 1 | Control word accepted this cycle |
| ctlPhase | input | 6 | Phase selecting the coefficient row |
| ctlShift | input | 1 | Move one pixel into the window |
| ctlEmit | input | 1 | Produce one output pixel |
| ctlEol | input | 1 | Line ends after this step |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Input pixel taken this cycle |
| inData | input | 8 | Input pixel |
| inLast | input | 1 | Input pixel is the last of its line |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Downstream takes the output pixel |
| outData | output | 8 | Output pixel |

## Verification
A coefficient write and an emit that reads the same word can land in the same cycle. The emit must still use the old taps. The bench provokes this with a directed case that rewrites the pair under the active phase during an emit. Random traffic also sends writes to arbitrary addresses alongside phase-selected emits. The bench model applies each write only after it has computed that cycle's expected pixel, so any early forwarding shows up as a data mismatch on the port.

// File: rtl/hscale_pkg.sv
package hscale_pkg;
  // per-step strobes from control to datapath
  typedef struct packed {
    logic load;   // shift in the offered pixel
    logic fill;   // replace whole window with the offered pixel
    logic repl;   // shift in a copy of the newest pixel
    logic emit;   // compute and register one output pixel
  } dpStrobe_t;
endpackage

// File: rtl/hscale_coef_bank.sv
module hscale_coef_bank #(
  parameter int NTAPS  = 6,
  parameter int PHASES = 64,
  parameter int COEF_W = 16,
  parameter int CFG_AW = 8,
  parameter int PH_W   = 6
) (
  input  logic                      clk,
  input  logic                      cfgWe,
  input  logic [CFG_AW-1:0]         cfgAddr,
  input  logic [2*COEF_W-1:0]       cfgData,
  input  logic [PH_W-1:0]           phase,
  output logic [NTAPS*COEF_W-1:0]   coefFlat
);
  localparam int PAIRS   = NTAPS / 2;
  localparam int WORDS   = PHASES * PAIRS;
  localparam int WORD_AW = $clog2(WORDS);
  localparam int WORD_W  = 2 * COEF_W;

  logic [WORD_W-1:0]  mem [WORDS];
  logic [WORD_AW-1:0] rowBase;
  logic               addrOk;

  assign addrOk  = {1'b0, cfgAddr} < (CFG_AW+1)'(WORDS);
  assign rowBase = WORD_AW'(phase) * WORD_AW'(PAIRS);

  always_ff @(posedge clk) begin
    if (cfgWe && addrOk) mem[cfgAddr[WORD_AW-1:0]] <= cfgData;
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic [WORD_W-1:0] word;
    assign word = mem[rowBase + WORD_AW'(j)];
    assign coefFlat[(2*j)*COEF_W   +: COEF_W] = word[COEF_W-1:0];
    assign coefFlat[(2*j+1)*COEF_W +: COEF_W] = word[WORD_W-1:COEF_W];
  end
endmodule

// File: rtl/hscale_ctrl.sv
module hscale_ctrl
  import hscale_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlValid,
  input  logic       ctlShift,
  input  logic       ctlEmit,
  input  logic       ctlEol,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       outValid,
  input  logic       outReady,
  output logic       ctlReady,
  output logic       inReady,
  output dpStrobe_t  st
);
  logic fresh;      // next shift starts a line
  logic exhausted;  // last pixel of the line already taken
  logic slotFree, needPix, emitOk, step, shiftIn;

  assign slotFree = !outValid || outReady;
  assign needPix  = ctlShift && !exhausted;
  assign emitOk   = !ctlEmit || slotFree;
  assign ctlReady = (!needPix || inValid) && emitOk;
  assign inReady  = ctlValid && needPix && emitOk;
  assign step     = ctlValid && ctlReady;
  assign shiftIn  = step && ctlShift;

  always_comb begin
    st      = '0;
    st.fill = shiftIn && needPix && fresh;
    st.load = shiftIn && needPix && !fresh;
    st.repl = shiftIn && !needPix;
    st.emit = step && ctlEmit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fresh     <= 1'b1;
      exhausted <= 1'b0;
    end else if (step) begin
      if (ctlEol) begin
        fresh     <= 1'b1;
        exhausted <= 1'b0;
      end else if (shiftIn && needPix) begin
        fresh <= 1'b0;
        if (inLast) exhausted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hscale_datapath.sv
module hscale_datapath
  import hscale_pkg::*;
#(
  parameter int NTAPS  = 6,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC   = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 st,
  input  logic [PIX_W-1:0]          inData,
  input  logic [NTAPS*COEF_W-1:0]   coefFlat,
  input  logic                      outReady,
  output logic                      outValid,
  output logic [PIX_W-1:0]          outData
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(NTAPS) + 1;
  localparam logic signed [ACC_W-1:0] ROUND   = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic [NTAPS-1:0][PIX_W-1:0] win, winNext;
  logic signed [PROD_W-1:0]    prod [NTAPS];
  logic signed [ACC_W-1:0]     acc, biased, shifted;
  logic [PIX_W-1:0]            pixOut;

  always_comb begin
    winNext = win;
    if (st.fill) begin
      for (int k = 0; k < NTAPS; k++) winNext[k] = inData;
    end else if (st.load || st.repl) begin
      for (int k = 0; k < NTAPS-1; k++) winNext[k] = win[k+1];
      winNext[NTAPS-1] = st.load ? inData : win[NTAPS-1];
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign prod[g] = $signed(coefFlat[g*COEF_W +: COEF_W]) * $signed({1'b0, winNext[g]});
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++)
      acc = acc + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
  end

  assign biased  = acc + ROUND;
  assign shifted = biased >>> FRAC;

  always_comb begin
    if (shifted < 0)             pixOut = '0;
    else if (shifted > PIX_MAX)  pixOut = '1;
    else                         pixOut = shifted[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      win      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      win <= winNext;
      if (st.emit) begin
        outValid <= 1'b1;
        outData  <= pixOut;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hscale_poly.sv
module hscale_poly
  import hscale_pkg::*;
#(
  parameter int NTAPS  = 6,
  parameter int PHASES = 64,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC   = 12,
  parameter int CFG_AW = 8,
  parameter int PH_W   = $clog2(PHASES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [2*COEF_W-1:0]  cfgData,
  input  logic                 ctlValid,
  output logic                 ctlReady,
  input  logic [PH_W-1:0]      ctlPhase,
  input  logic                 ctlShift,
  input  logic                 ctlEmit,
  input  logic                 ctlEol,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [PIX_W-1:0]     inData,
  input  logic                 inLast,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [PIX_W-1:0]     outData
);
  dpStrobe_t                  st;
  logic [NTAPS*COEF_W-1:0]    coefFlat;

  hscale_coef_bank #(.NTAPS(NTAPS), .PHASES(PHASES), .COEF_W(COEF_W),
                     .CFG_AW(CFG_AW), .PH_W(PH_W)) u_bank (
    .clk(clk), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .phase(ctlPhase), .coefFlat(coefFlat));

  hscale_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlValid(ctlValid), .ctlShift(ctlShift),
    .ctlEmit(ctlEmit), .ctlEol(ctlEol), .inValid(inValid), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .ctlReady(ctlReady),
    .inReady(inReady), .st(st));

  hscale_datapath #(.NTAPS(NTAPS), .PIX_W(PIX_W), .COEF_W(COEF_W),
                    .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .coefFlat(coefFlat),
    .outReady(outReady), .outValid(outValid), .outData(outData));
endmodule

// File: rtl/hscale_poly_checker.sv
module hscale_poly_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlValid,
  input logic             ctlReady,
  input logic             ctlEmit,
  input logic             ctlEol,
  input logic             inValid,
  input logic             inReady,
  input logic             inLast,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outData
);
  logic sawLast;

  always_ff @(posedge clk) begin
    if (!rstN) sawLast <= 1'b0;
    else if (ctlValid && ctlReady && ctlEol) sawLast <= 1'b0;
    else if (inValid && inReady && inLast) sawLast <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !outValid);

  assert_no_input_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    sawLast |-> !inReady);

  assert_take_only_on_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (ctlValid && ctlReady));

  assert_emit_yields_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlValid && ctlReady && ctlEmit) |=> outValid);

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

bind hscale_poly hscale_poly_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctlValid(ctlValid), .ctlReady(ctlReady),
  .ctlEmit(ctlEmit), .ctlEol(ctlEol), .inValid(inValid), .inReady(inReady),
  .inLast(inLast), .outValid(outValid), .outReady(outReady), .outData(outData));

// File: tb/hscale_poly_test.sv
module hscale_poly_test;
  localparam int N = 6, PAIRS = 3, WORDS = 192;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0; logic [7:0] cfgAddr = 0; logic [31:0] cfgData = 0;
  logic ctlValid = 0, ctlShift = 0, ctlEmit = 0, ctlEol = 0;
  logic [5:0] ctlPhase = 0;
  logic inValid = 0, inLast = 0, outReady = 0;
  logic [7:0] inData = 0;
  logic ctlReady, inReady, outValid;
  logic [7:0] outData;

  always #2 clk = ~clk;

  hscale_poly uut (.clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .ctlValid(ctlValid), .ctlReady(ctlReady),
    .ctlPhase(ctlPhase), .ctlShift(ctlShift), .ctlEmit(ctlEmit),
    .ctlEol(ctlEol), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outReady(outReady),
    .outData(outData));

  int nChk = 0, nBad = 0;
  bit done = 0;
  string curTag = "R4";
  logic [31:0] mMem [WORDS];
  int mWin [N];
  bit mFresh = 1, mExh = 0, mOutV = 0;
  int mOutD = 0;

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int coefOf(int ph, int k);
    logic [31:0] w;
    logic signed [15:0] h;
    w = mMem[ph*PAIRS + k/2];
    h = (k % 2) ? w[31:16] : w[15:0];
    return int'(h);
  endfunction

  function automatic int calc(int ph);
    int s = 0, r;
    for (int k = 0; k < N; k++) s += coefOf(ph, k) * mWin[k];
    r = (s + 2048) >>> 12;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic cyc(bit v, int ph, bit sh, bit em, bit eol, bit iv, int pix,
                     bit il, bit ordy, bit we, int addr, logic [31:0] dat);
    bit needPix, slot, expRdy, expIn, fire;
    @(negedge clk);
    check("R9", int'(outValid), int'(mOutV));
    if (mOutV && outValid) check(curTag, int'(outData), mOutD);
    ctlValid = v; ctlPhase = 6'(ph); ctlShift = sh; ctlEmit = em; ctlEol = eol;
    inValid = iv; inData = 8'(pix); inLast = il; outReady = ordy;
    cfgWe = we; cfgAddr = 8'(addr); cfgData = dat;
    #1;
    needPix = sh && !mExh;
    slot    = !mOutV || ordy;
    expRdy  = (!needPix || iv) && (!em || slot);
    expIn   = v && needPix && (!em || slot);
    check("R8", int'(ctlReady), int'(expRdy));
    check("R7", int'(inReady), int'(expIn));
    fire = v && expRdy;
    if (fire && sh) begin
      if (needPix && mFresh) begin
        for (int k = 0; k < N; k++) mWin[k] = pix;
      end else begin
        for (int k = 0; k < N-1; k++) mWin[k] = mWin[k+1];
        if (needPix) mWin[N-1] = pix;
      end
    end
    if (fire && em) begin
      mOutV = 1; mOutD = calc(ph);
    end else if (ordy) mOutV = 0;
    if (fire) begin
      if (eol) begin mFresh = 1; mExh = 0; end
      else if (sh && needPix) begin mFresh = 0; if (il) mExh = 1; end
    end
    if (we && addr < WORDS) mMem[addr] = dat;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic step(int ph, bit sh, bit em, bit eol, int pix, bit il);
    cyc(1, ph, sh, em, eol, 1, pix, il, 1, 0, 0, 0);
  endtask

  task automatic wr(int addr, logic [31:0] dat);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, addr, dat);
  endtask

  function automatic logic [31:0] genWord(int a);
    int s0, s1;
    if (a / PAIRS < 32) begin
      s0 = $urandom_range(0, 1365); s1 = $urandom_range(0, 1365);
    end else begin
      s0 = int'($urandom_range(0, 8190)) - 4095;
      s1 = int'($urandom_range(0, 8190)) - 4095;
    end
    return {16'(s1), 16'(s0)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(outValid), 0);
    check("R1", int'(ctlReady), 1);
    check("R1", int'(inReady), 0);

    for (int a = 0; a < WORDS; a++) wr(a, genWord(a));

    curTag = "R6";
    step(5, 1, 1, 0, 100, 0);
    step(9, 1, 1, 0, 37, 0);
    idle(1);

    curTag = "R2";
    wr(7*PAIRS + 0, {16'd0, 16'd4096});
    wr(7*PAIRS + 1, 32'd0);
    wr(7*PAIRS + 2, 32'd0);
    step(7, 1, 1, 0, 10, 0);
    step(7, 1, 1, 0, 20, 0);
    wr(7*PAIRS + 0, 32'd0);
    wr(7*PAIRS + 2, {16'd4096, 16'd0});
    step(7, 1, 1, 0, 30, 0);
    wr(7*PAIRS + 1, {16'hF800, 16'd2048});
    step(7, 0, 1, 0, 0, 0);

    curTag = "R3";
    wr(200, 32'h7FFF7FFF);
    wr(255, 32'h80008000);
    step(2, 0, 1, 0, 0, 0);
    step(63, 0, 1, 0, 0, 0);
    step(21, 0, 1, 0, 0, 0);

    curTag = "R5";
    for (int j = 0; j < PAIRS; j++) wr(40*PAIRS + j, 32'h7FFF7FFF);
    for (int j = 0; j < PAIRS; j++) wr(41*PAIRS + j, 32'h80008000);
    step(0, 0, 0, 1, 0, 0);
    step(40, 1, 1, 0, 255, 0);
    step(41, 0, 1, 0, 0, 0);
    step(40, 1, 1, 0, 0, 0);

    curTag = "R10";
    step(7, 1, 1, 0, 200, 0);
    cyc(1, 7, 0, 1, 0, 1, 0, 0, 1, 1, 7*PAIRS + 2, {16'd0, 16'd4096});
    step(7, 0, 1, 0, 0, 0);

    curTag = "R7";
    step(0, 0, 0, 1, 0, 0);
    step(3, 1, 1, 0, 50, 0);
    step(3, 1, 1, 0, 60, 0);
    step(3, 1, 1, 0, 70, 1);
    step(3, 1, 1, 0, 99, 0);
    step(3, 1, 1, 0, 11, 0);
    cyc(1, 3, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0);

    curTag = "R9";
    cyc(1, 12, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 13, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 14, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 15, 0, 1, 0, 1, 0, 0, 1, 0, 0, 0);
    idle(1);

    curTag = "R11";
    step(0, 0, 0, 1, 0, 0);
    step(20, 1, 1, 0, 180, 0);
    step(20, 1, 1, 0, 90, 0);
    idle(1);

    curTag = "R4";
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom_range(0, 9) == 0);
      cyc($urandom_range(0, 7) != 0, $urandom_range(0, 63),
          $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 24) == 0, $urandom_range(0, 3) != 0,
          $urandom_range(0, 255), $urandom_range(0, 11) == 0,
          $urandom_range(0, 3) != 0, we, $urandom_range(0, 255),
          genWord($urandom_range(0, WORDS-1)));
    end
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule